// File: doc/BRIEF.md
# Flag-Driven Event Counter Pair

This block keeps two 8-bit event counters that follow a state machine sitting elsewhere in the chip. Each time that machine takes a transition, it raises a one-cycle transition strobe. Along with the strobe it presents two flag bits that belong to the state it is entering. The first counter, A, can step up or down. It steps up on the "up" flag and down on the "down" flag, and each direction has its own enable. If both directions fire on the same transition, they cancel. The second counter, B, only steps down, on the "down" flag. Both counters wrap modulo 256. A transition back into the same state is still a transition and is counted.

Software-side reads arrive as a level access signal. When an access begins, both counters are copied into a held read register. Counting is suspended for the length of the access. The first event seen during the access is remembered and applied once the access ends, and any further events in that access are dropped. A clear-on-read option zeroes both counters at the end of the access, before the remembered event is applied. The read port has no back-pressure: the captured value stays on the output until the next access begins, so a consumer may take it at any later cycle. Pulling the module enable low holds everything at zero.

Top module: `evc_pair`

## Requirements
- R1: A strobe with the up flag set and `a_inc_en` high, and without a cancelling down step, increments counter A by one. A wraps from 255 to 0.
- R2: A strobe with the down flag set and `a_dec_en` high, and without a cancelling up step, decrements counter A by one. A wraps from 0 to 255.
- R3: When both flags are set and both of A's enables are high on one strobe, A keeps its value.
- R4: A strobe with the down flag set and `b_dec_en` high decrements counter B. This includes going from 0 to 255 on the first count after reset. The up flag never changes B.
- R5: A count takes effect at the clock edge that samples the strobe. A strobe held high for N consecutive cycles counts N transitions, including same-state transitions. A strobe with no enabled flag changes nothing.
- R6: On the first cycle that `rd_active` is high, `rd_data` captures {B in bits 15:8, A in bits 7:0}. It shows that value from the next cycle on and holds it until the next access starts. After reset `rd_data` is 0.
- R7: While `rd_active` is high, the counters do not change. The step of the first strobe seen during the access is applied at the edge where `rd_active` is first seen low again. Later strobes in the same access are discarded.
- R8: If `clr_on_rd` is high on the first cycle of an access, both counters become 0 at the end of the access, and then any deferred step is added. If it is low, the read leaves the counters unchanged.
- R9: While `mod_en` is low, both counters, the deferred step and `rd_data` are forced to 0 at the next edge, and strobes are ignored.
- R10: A strobe in the cycle where an access ends is counted in addition to the deferred step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_en | input | 1 | Module enable; low holds all state at zero |
| evt_strobe | input | 1 | One cycle per state-machine transition |
| flag_up | input | 1 | First flag of the state being entered |
| flag_dn | input | 1 | Second flag of the state being entered |
| a_inc_en | input | 1 | Lets the up flag increment counter A |
| a_dec_en | input | 1 | Lets the down flag decrement counter A |
| b_dec_en | input | 1 | Lets the down flag decrement counter B |
| clr_on_rd | input | 1 | Zero both counters at the end of each read access |
| rd_active | input | 1 | High for the duration of a read access |
| rd_data | output | 16 | Captured {B, A} from the latest access start |

## Verification
A strobe driven before edge t is visible in the counters after edge t. A read that begins at edge t+1 presents the value on `rd_data` half a cycle later. The bench therefore drives on the falling edge and checks `rd_data` on the falling edge after the capture edge. A deferred step lands at the first edge that samples `rd_active` low, so the bench always closes the access and then runs a fresh read before it compares the counters. Checks made inside an access compare against the value from before the access, which confirms that mid-access events do not leak into the read data.

// File: rtl/evc_pkg.sv
package evc_pkg;
  // Signed step of one counter for one event: -1, 0 or +1.
  typedef logic signed [1:0] step_t;

  localparam step_t STEP_UP   = 2'sd1;
  localparam step_t STEP_DOWN = -2'sd1;
  localparam step_t STEP_NONE = 2'sd0;

  // Sign-extend a step to a counter width.
  function automatic logic [31:0] step_ext32(input step_t s);
    return {{30{s[1]}}, s};
  endfunction
endpackage

// File: rtl/evc_step.sv
module evc_step
  import evc_pkg::*;
#(
  parameter bit UP_OK = 1'b1
) (
  input  logic  flag_up,
  input  logic  flag_dn,
  input  logic  en_up,
  input  logic  en_dn,
  output step_t step
);
  logic want_up, want_dn;

  assign want_dn = flag_dn & en_dn;

  generate
    if (UP_OK) begin : g_bidir
      assign want_up = flag_up & en_up;
      always_comb begin
        if (want_up && !want_dn)      step = STEP_UP;
        else if (want_dn && !want_up) step = STEP_DOWN;
        else                          step = STEP_NONE;
      end
    end else begin : g_down_only
      logic unused_up;
      assign unused_up = flag_up ^ en_up;
      assign want_up   = 1'b0;
      always_comb step = want_dn ? STEP_DOWN : STEP_NONE;
    end
  endgenerate
endmodule

// File: rtl/evc_read_ctrl.sv
module evc_read_ctrl
  import evc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  mod_en,
  input  logic  rd_active,
  input  logic  clr_on_rd,
  input  logic  evt_strobe,
  input  step_t new_a,
  input  step_t new_b,
  output logic  rd_start,
  output logic  rd_end,
  output logic  clear_now,
  output step_t defer_a,
  output step_t defer_b
);
  logic  was_rd;
  logic  clr_lat;
  logic  pend_v;
  step_t pend_a, pend_b;

  assign rd_start  = rd_active & ~was_rd;
  assign rd_end    = ~rd_active & was_rd;
  assign clear_now = rd_end & clr_lat;
  assign defer_a   = (rd_end && pend_v) ? pend_a : STEP_NONE;
  assign defer_b   = (rd_end && pend_v) ? pend_b : STEP_NONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      was_rd  <= 1'b0;
      clr_lat <= 1'b0;
      pend_v  <= 1'b0;
      pend_a  <= STEP_NONE;
      pend_b  <= STEP_NONE;
    end else if (!mod_en) begin
      was_rd  <= 1'b0;
      clr_lat <= 1'b0;
      pend_v  <= 1'b0;
      pend_a  <= STEP_NONE;
      pend_b  <= STEP_NONE;
    end else begin
      was_rd <= rd_active;
      if (rd_start) clr_lat <= clr_on_rd;
      if (rd_end) begin
        pend_v <= 1'b0;
        pend_a <= STEP_NONE;
        pend_b <= STEP_NONE;
      end else if (rd_active && evt_strobe && !pend_v) begin
        pend_v <= 1'b1;
        pend_a <= new_a;
        pend_b <= new_b;
      end
    end
  end

  // Only the first event of an access is kept (R7)
  assert_one_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en && pend_v && rd_active) |=>
      (!mod_en || (pend_v && pend_a == $past(pend_a) && pend_b == $past(pend_b))));
endmodule

// File: rtl/evc_counter.sv
module evc_counter
  import evc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mod_en,
  input  logic         freeze,
  input  logic         clear,
  input  step_t        step_a,
  input  step_t        step_b,
  output logic [W-1:0] q
);
  logic [31:0]  ext_a32, ext_b32;
  logic [W-1:0] ext_a, ext_b, base, nxt;

  assign ext_a32 = step_ext32(step_a);
  assign ext_b32 = step_ext32(step_b);
  assign ext_a   = ext_a32[W-1:0];
  assign ext_b   = ext_b32[W-1:0];
  assign base    = clear ? '0 : q;
  assign nxt     = base + ext_a + ext_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= '0;
    else if (!mod_en) q <= '0;
    else if (!freeze) q <= nxt;
  end

  // Disabled module drives the count to zero (R9)
  assert_off_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_en |=> q == '0);

  // No counting while an access is open (R7)
  assert_read_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en && freeze) |=> (!mod_en || q == $past(q)));
endmodule

// File: rtl/evc_pair.sv
module evc_pair
  import evc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mod_en,
  input  logic               evt_strobe,
  input  logic               flag_up,
  input  logic               flag_dn,
  input  logic               a_inc_en,
  input  logic               a_dec_en,
  input  logic               b_dec_en,
  input  logic               clr_on_rd,
  input  logic               rd_active,
  output logic [2*CNT_W-1:0] rd_data
);
  localparam int RD_W = 2 * CNT_W;
  localparam int NCNT = 2;

  step_t new_step [NCNT];
  step_t def_step [NCNT];
  step_t live_step[NCNT];
  logic [CNT_W-1:0] cnt [NCNT];
  logic rd_start, rd_end, clear_now;

  // Counter 0 = A (up/down), counter 1 = B (down only)
  generate
    for (genvar i = 0; i < NCNT; i++) begin : g_cnt
      evc_step #(.UP_OK(i == 0)) u_step (
        .flag_up (flag_up),
        .flag_dn (flag_dn),
        .en_up   (i == 0 ? a_inc_en : 1'b0),
        .en_dn   (i == 0 ? a_dec_en : b_dec_en),
        .step    (new_step[i])
      );

      assign live_step[i] = (evt_strobe && !rd_active) ? new_step[i] : STEP_NONE;

      evc_counter #(.W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .mod_en (mod_en),
        .freeze (rd_active),
        .clear  (clear_now),
        .step_a (def_step[i]),
        .step_b (live_step[i]),
        .q      (cnt[i])
      );
    end
  endgenerate

  evc_read_ctrl u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .mod_en     (mod_en),
    .rd_active  (rd_active),
    .clr_on_rd  (clr_on_rd),
    .evt_strobe (evt_strobe),
    .new_a      (new_step[0]),
    .new_b      (new_step[1]),
    .rd_start   (rd_start),
    .rd_end     (rd_end),
    .clear_now  (clear_now),
    .defer_a    (def_step[0]),
    .defer_b    (def_step[1])
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rd_data <= '0;
    else if (!mod_en)  rd_data <= '0;
    else if (rd_start) rd_data <= {cnt[1], cnt[0]};
  end

  // Read data is the count seen at the access start (R6)
  assert_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en && rd_start) |=>
      (!mod_en || rd_data == RD_W'({$past(cnt[1]), $past(cnt[0])})));

  // Opposite directions on counter A cancel (R3)
  assert_cancel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_up && flag_dn && a_inc_en && a_dec_en) |-> new_step[0] == STEP_NONE);
endmodule

// File: tb/evc_pair_test.sv
module evc_pair_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mod_en = 1'b0, evt_strobe = 1'b0, flag_up = 1'b0, flag_dn = 1'b0;
  logic a_inc_en = 1'b0, a_dec_en = 1'b0, b_dec_en = 1'b0;
  logic clr_on_rd = 1'b0, rd_active = 1'b0;
  logic [15:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  evc_pair uut (
    .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .evt_strobe(evt_strobe),
    .flag_up(flag_up), .flag_dn(flag_dn), .a_inc_en(a_inc_en),
    .a_dec_en(a_dec_en), .b_dec_en(b_dec_en), .clr_on_rd(clr_on_rd),
    .rd_active(rd_active), .rd_data(rd_data)
  );

  // {inc_en, dec_en, b_en, flag_up, flag_dn, expected A, expected B}
  localparam logic [20:0] VEC [8] = '{
    {5'b10010, 8'd1,   8'd0  },
    {5'b01101, 8'd0,   8'd255},
    {5'b11111, 8'd0,   8'd254},
    {5'b01110, 8'd0,   8'd254},
    {5'b01001, 8'd255, 8'd254},
    {5'b10010, 8'd0,   8'd254},
    {5'b00101, 8'd0,   8'd253},
    {5'b10011, 8'd1,   8'd253}
  };

  task automatic check(input string req, input logic [15:0] exp);
    checks++;
    if (rd_data !== exp) begin
      errors++;
      $display("FAIL %s: actual A=%0d B=%0d expected A=%0d B=%0d",
               req, rd_data[7:0], rd_data[15:8], exp[7:0], exp[15:8]);
    end
  endtask

  task automatic set_ctl(input logic [4:0] c);
    {a_inc_en, a_dec_en, b_dec_en, flag_up, flag_dn} = c;
  endtask

  // One strobe cycle, then strobe low
  task automatic pulse();
    @(negedge clk) evt_strobe = 1'b1;
    @(negedge clk) evt_strobe = 1'b0;
  endtask

  // One-cycle read access, then compare captured value
  task automatic read_chk(input string req, input logic [7:0] ea, input logic [7:0] eb);
    @(negedge clk) rd_active = 1'b1;
    @(negedge clk) rd_active = 1'b0;
    check(req, {eb, ea});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R6 reset value", 16'h0000);
    mod_en = 1'b1;
    read_chk("R6 first read after reset", 8'd0, 8'd0);

    // Vector table: R1 R2 R3 R4 R5
    for (int i = 0; i < 8; i++) begin
      set_ctl(VEC[i][20:16]);
      pulse();
      set_ctl(5'b0);
      read_chk($sformatf("vector %0d (R1 R2 R3 R4 R5)", i), VEC[i][15:8], VEC[i][7:0]);
    end

    // R5: strobe held three cycles, same-state transitions each count
    set_ctl(5'b10010);
    @(negedge clk) evt_strobe = 1'b1;
    repeat (3) @(negedge clk);
    evt_strobe = 1'b0;
    read_chk("R5 back-to-back strobes", 8'd4, 8'd253);

    // R7: events during access are deferred and merged
    @(negedge clk) begin rd_active = 1'b1; evt_strobe = 1'b1; end
    repeat (2) @(negedge clk);
    check("R7 capture ignores in-access events", {8'd253, 8'd4});
    rd_active = 1'b0;
    evt_strobe = 1'b0;
    read_chk("R7 single deferred count", 8'd5, 8'd253);

    // R10: strobe in the ending cycle adds to the deferred step
    @(negedge clk) begin rd_active = 1'b1; evt_strobe = 1'b1; end
    @(negedge clk) rd_active = 1'b0;
    @(negedge clk) evt_strobe = 1'b0;
    read_chk("R10 end-cycle strobe plus deferred", 8'd7, 8'd253);

    // R8: clear-on-read with a pending down step
    set_ctl(5'b01101);
    clr_on_rd = 1'b1;
    @(negedge clk) begin rd_active = 1'b1; evt_strobe = 1'b1; end
    @(negedge clk) begin evt_strobe = 1'b0; rd_active = 1'b0; end
    check("R8 capture before clear", {8'd253, 8'd7});
    clr_on_rd = 1'b0;
    set_ctl(5'b0);
    read_chk("R8 clear then deferred step", 8'd255, 8'd255);
    clr_on_rd = 1'b1;
    read_chk("R8 clearing read returns old value", 8'd255, 8'd255);
    clr_on_rd = 1'b0;
    read_chk("R8 counters cleared", 8'd0, 8'd0);
    read_chk("R8 plain read leaves value", 8'd0, 8'd0);

    // R9: module disable zeroes and ignores strobes
    set_ctl(5'b11111);
    pulse();
    read_chk("R9 setup count", 8'd0, 8'd255);
    @(negedge clk) mod_en = 1'b0;
    pulse();
    pulse();
    check("R9 read data zero while disabled", 16'h0000);
    @(negedge clk) mod_en = 1'b1;
    set_ctl(5'b0);
    read_chk("R9 counters zero after re-enable", 8'd0, 8'd0);

    // R2: down wrap from zero on counter A alone
    set_ctl(5'b01001);
    pulse();
    set_ctl(5'b0);
    read_chk("R2 A wraps 0 to 255", 8'd255, 8'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule